// File: doc/BRIEF.md
# Split-Word Position Readout over SPI

This block lets an external SPI master read a 20-bit position value held by the core. The master runs two back-to-back 16-bit transfers. The first returns the upper ten bits of the position and the second returns the lower ten. Each transfer carries two status flags: one marks which half it holds, and one shows whether the core is in absolute or incremental mode. Each transfer also carries an even-parity bit for each of its two bytes. The serial pins are asynchronous to the system clock, so they are synchronized into it, and their edges are detected there.

When chip select falls at the start of an upper-half transfer, the block captures the position word and the mode flag. The lower-half transfer that follows is served from that capture, so both halves always describe the same sample. The block only transmits, so it has no MOSI input. The pad driver uses the output-enable signal to tri-state MISO whenever chip select is high. If a transfer is cut short, the pairing starts again with an upper half. The serial clock is meant to run at 1 MHz or below, with readouts at 20 kHz or below. The synchronizers need the system clock to be at least about eight times faster than the serial clock.

Top module: `spi_pos_readout`

## Requirements
- R1: Each transfer is 16 bits, most significant bit first, in SPI mode 0. The first bit is on `miso_o` after chip select has fallen and before the first rising serial clock edge. Each following bit appears after a falling serial clock edge.
- R2: A completed upper-half transfer (chip select rises after exactly 16 rising serial clock edges) is followed by a lower-half transfer. A completed lower-half transfer is followed by an upper-half transfer.
- R3: Upper-half frame: bit 15 = 1 (half flag), bit 14 = mode flag, bits 13..9 = position bits 19..15, bits 7..3 = position bits 14..10, bits 2..1 = 0.
- R4: Lower-half frame: bit 15 = 0, bit 14 = mode flag, bits 13..9 = position bits 9..5, bits 7..3 = position bits 4..0, bits 2..1 = 0.
- R5: Bit 8 makes the number of ones in bits 15..8 even, and bit 0 makes the number of ones in bits 7..0 even.
- R6: Position and mode are captured when chip select falls for an upper-half transfer. The lower-half transfer uses that capture, and changes on `pos_i` or `abs_mode_i` in the meantime have no effect on it.
- R7: If chip select rises after fewer than 16 rising serial clock edges, the transfer is abandoned and the next transfer is an upper half.
- R8: While chip select is high, `miso_oe_o` is 0 and `miso_o` is 0.
- R9: After synchronous reset, the first transfer is an upper half and `miso_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | SPI chip select from master, active low, asynchronous |
| sclk_i | input | 1 | SPI serial clock from master, asynchronous |
| pos_i | input | 20 | Position word from the core |
| abs_mode_i | input | 1 | Core mode flag: 1 = absolute, 0 = incremental |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Drive enable for the MISO pad (tri-state when 0) |

## Verification
On every cycle, the assertions check four things. The bit counter never passes 16. The half alternates only after a full 16-edge transfer and falls back to upper after a short one. The capture stays still through a lower-half transfer. Every loaded frame has even parity in both bytes. The bench sweeps many position and mode patterns, and those scenarios alone show the following: the bit order seen on the wire, the exact placement of fields in each half, that the lower half ignores a new position, and the idle pad state between transfers.

// File: rtl/spi_pos_pkg.sv
package spi_pos_pkg;

    localparam int POS_W   = 20;
    localparam int FRAME_W = 16;
    localparam int HALF_W  = POS_W / 2;
    localparam int SEG_W   = HALF_W / 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    // One serial word as it appears on the wire, MSB first
    typedef struct packed {
        logic             is_upper;
        logic             abs_mode;
        logic [SEG_W-1:0] seg_a;
        logic             par_a;
        logic [SEG_W-1:0] seg_b;
        logic [1:0]       spare;
        logic             par_b;
    } frame_t;

    // Synchronized pin level with edge strobes
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_ev_t;

    // Captured sample shared by both halves
    typedef struct packed {
        logic             abs_mode;
        logic [POS_W-1:0] pos;
    } sample_t;

    function automatic frame_t build_frame(input logic upper, input sample_t s);
        frame_t           f;
        logic [HALF_W-1:0] part;
        part       = upper ? s.pos[POS_W-1:HALF_W] : s.pos[HALF_W-1:0];
        f.is_upper = upper;
        f.abs_mode = s.abs_mode;
        f.seg_a    = part[HALF_W-1:SEG_W];
        f.seg_b    = part[SEG_W-1:0];
        f.spare    = 2'b00;
        f.par_a    = ^{f.is_upper, f.abs_mode, f.seg_a};
        f.par_b    = ^{f.seg_b, f.spare};
        return f;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_pos_pkg::*;
#(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    pin_i,
    output pin_ev_t ev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        ev_o.lvl  = prev_q;
        ev_o.rise = chain_q[STAGES-1] & ~prev_q;
        ev_o.fall = ~chain_q[STAGES-1] & prev_q;
    end

    assert_edges_exclusive_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        !(ev_o.rise && ev_o.fall));

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_pos_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  pin_ev_t          cs_ev_i,
    input  pin_ev_t          sclk_ev_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             abs_mode_i,
    output logic             load_o,
    output frame_t           frame_o,
    output logic             active_o
);
    logic              expect_upper_q;
    logic              active_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    sample_t           snap_q;
    sample_t           live;
    sample_t           chosen;
    logic              full_frame;

    assign live.pos      = pos_i;
    assign live.abs_mode = abs_mode_i;
    assign chosen        = expect_upper_q ? live : snap_q;
    assign full_frame    = (bit_cnt_q == CNT_W'(FRAME_W));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            expect_upper_q <= 1'b1;
            active_q       <= 1'b0;
            bit_cnt_q      <= '0;
            snap_q         <= '0;
        end else begin
            if (cs_ev_i.fall) begin
                active_q  <= 1'b1;
                bit_cnt_q <= '0;
                if (expect_upper_q) snap_q <= live;
            end else if (cs_ev_i.rise) begin
                active_q       <= 1'b0;
                expect_upper_q <= (active_q && full_frame) ? ~expect_upper_q : 1'b1;
            end else if (active_q && sclk_ev_i.rise && !full_frame) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    assign load_o   = cs_ev_i.fall;
    assign frame_o  = build_frame(expect_upper_q, chosen);
    assign active_o = active_q;

    assert_bitcnt_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_cnt_q <= CNT_W'(FRAME_W));

    assert_upper_to_lower_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_ev_i.rise && active_q && full_frame && expect_upper_q) |=> !expect_upper_q);

    assert_lower_to_upper_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_ev_i.rise && active_q && full_frame && !expect_upper_q) |=> expect_upper_q);

    assert_abort_restart_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_ev_i.rise && !full_frame) |=> expect_upper_q);

    assert_snapshot_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!expect_upper_q && !cs_ev_i.fall) |=> $stable(snap_q));

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
    import spi_pos_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    load_i,
    input  frame_t  frame_i,
    input  pin_ev_t cs_ev_i,
    input  pin_ev_t sclk_ev_i,
    output logic    miso_o,
    output logic    oe_o
);
    logic [FRAME_W-1:0] shreg_q;
    logic               oe_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg_q <= '0;
            oe_q    <= 1'b0;
        end else if (load_i) begin
            shreg_q <= frame_i;
            oe_q    <= 1'b1;
        end else if (cs_ev_i.rise) begin
            shreg_q <= '0;
            oe_q    <= 1'b0;
        end else if (oe_q && sclk_ev_i.fall) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign miso_o = shreg_q[FRAME_W-1] & oe_q;
    assign oe_o   = oe_q;

    always @(posedge clk_i) begin
        if (!rst_i && load_i) begin
            assert_parity_even_R5: assert ((^frame_i[15:8]) == 1'b0 && (^frame_i[7:0]) == 1'b0);
        end
    end

endmodule

// File: rtl/spi_pos_readout.sv
module spi_pos_readout
    import spi_pos_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             abs_mode_i,
    output logic             miso_o,
    output logic             miso_oe_o
);
    localparam int         NPINS    = 2;
    localparam logic [1:0] PIN_IDLE = 2'b01; // [0] chip select idles high, [1] clock idles low

    logic [NPINS-1:0] raw_pins;
    pin_ev_t          ev [NPINS];
    logic             load;
    frame_t           frame;
    logic             active;

    assign raw_pins = {sclk_i, cs_n_i};

    for (genvar i = 0; i < NPINS; i++) begin : g_sync
        spi_pin_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (PIN_IDLE[i])
        ) u_sync (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .pin_i (raw_pins[i]),
            .ev_o  (ev[i])
        );
    end

    spi_frame_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cs_ev_i    (ev[0]),
        .sclk_ev_i  (ev[1]),
        .pos_i      (pos_i),
        .abs_mode_i (abs_mode_i),
        .load_o     (load),
        .frame_o    (frame),
        .active_o   (active)
    );

    spi_tx_shifter u_tx (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (load),
        .frame_i   (frame),
        .cs_ev_i   (ev[0]),
        .sclk_ev_i (ev[1]),
        .miso_o    (miso_o),
        .oe_o      (miso_oe_o)
    );

    assert_oe_tracks_frame_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        miso_oe_o == active);

    assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !miso_oe_o |-> !miso_o);

endmodule

// File: tb/spi_pos_readout_tb.sv
module spi_pos_readout_tb;

    localparam int HP = 8; // serial half period in system clocks

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [19:0] pos = '0;
    logic        absm = 1'b0;
    logic        miso;
    logic        oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk; // 50 MHz

    spi_pos_readout u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .cs_n_i     (cs_n),
        .sclk_i     (sclk),
        .pos_i      (pos),
        .abs_mode_i (absm),
        .miso_o     (miso),
        .miso_oe_o  (oe)
    );

    function automatic logic [15:0] expect_word(input logic upper, input logic m, input logic [19:0] p);
        logic [9:0]  h;
        logic [15:0] w;
        int          ones;
        h = upper ? p[19:10] : p[9:0];
        w = {upper, m, h[9:5], 1'b0, h[4:0], 2'b00, 1'b0};
        ones = 0;
        for (int b = 9; b < 16; b++) ones += int'(w[b]);
        w[8] = ones[0];
        ones = 0;
        for (int b = 1; b < 8; b++) ones += int'(w[b]);
        w[0] = ones[0];
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Runs nbits serial clocks; returns the bits seen before each rising edge
    task automatic transfer(input int nbits, output logic [15:0] word, output logic oe_ok);
        word  = '0;
        oe_ok = 1'b1;
        cs_n  = 1'b0;
        wait_clk(HP);
        for (int b = 0; b < nbits; b++) begin
            word  = {word[14:0], miso};
            oe_ok = oe_ok & oe;
            sclk  = 1'b1;
            wait_clk(HP);
            sclk  = 1'b0;
            wait_clk(HP);
        end
        cs_n = 1'b1;
        wait_clk(HP);
    endtask

    task automatic read_pair(input logic [19:0] p, input logic m, input logic [19:0] p2, input logic m2);
        logic [15:0] w;
        logic        ok;
        pos = p; absm = m;
        transfer(16, w, ok);
        check("R1/R3/R5 upper frame", {16'h0, w}, {16'h0, expect_word(1'b1, m, p)});
        check("R1 oe during frame", {31'h0, ok}, 32'h1);
        pos = p2; absm = m2; // must not affect lower half (R6)
        transfer(16, w, ok);
        check("R2/R4/R5/R6 lower frame", {16'h0, w}, {16'h0, expect_word(1'b0, m, p)});
        check("R8 idle pad", {30'h0, oe, miso}, 32'h0);
    endtask

    initial begin
        logic [15:0] w;
        logic        ok;
        logic [19:0] p;
        wait_clk(4);
        check("R9 oe after reset", {31'h0, oe}, 32'h0);
        rst = 1'b0;
        wait_clk(4);
        check("R8 idle after reset", {30'h0, oe, miso}, 32'h0);

        // R9: first transfer is upper half
        pos = 20'hA5C3E; absm = 1'b1;
        transfer(16, w, ok);
        check("R9 first frame upper", {16'h0, w}, {16'h0, expect_word(1'b1, 1'b1, 20'hA5C3E)});
        transfer(16, w, ok);
        check("R4 lower after first", {16'h0, w}, {16'h0, expect_word(1'b0, 1'b1, 20'hA5C3E)});

        // corner values
        read_pair(20'h00000, 1'b0, 20'hFFFFF, 1'b1);
        read_pair(20'hFFFFF, 1'b1, 20'h00000, 1'b0);
        read_pair(20'hFFFFF, 1'b0, 20'h12345, 1'b1);

        // walking ones over every position bit (R3, R4)
        for (int i = 0; i < 20; i++) begin
            p = 20'h1 << i;
            read_pair(p, i[0], ~p, ~i[0]);
        end

        // arithmetic sweep
        for (int i = 0; i < 60; i++) begin
            p = 20'(i * 20'h2B3D7 + i * i * 331);
            read_pair(p, i[1], p ^ 20'h5A5A5, i[0]);
        end

        // R7: abandon an upper half after several lengths, next must be upper
        for (int n = 0; n < 16; n += 5) begin
            pos = 20'h3C0F1 + 20'(n); absm = 1'b1;
            transfer(n, w, ok);
            pos = 20'h6E2D9 + 20'(n); absm = 1'b0;
            transfer(16, w, ok);
            check("R7 restart upper after abort", {16'h0, w},
                  {16'h0, expect_word(1'b1, 1'b0, 20'h6E2D9 + 20'(n))});
            transfer(16, w, ok);
        end

        // R7: abandon a lower half, next must be upper
        pos = 20'h81234; absm = 1'b1;
        transfer(16, w, ok);
        transfer(9, w, ok);
        pos = 20'h4BEEF; absm = 1'b0;
        transfer(16, w, ok);
        check("R7 upper after aborted lower", {16'h0, w}, {16'h0, expect_word(1'b1, 1'b0, 20'h4BEEF)});
        transfer(16, w, ok);
        check("R2 lower follows", {16'h0, w}, {16'h0, expect_word(1'b0, 1'b0, 20'h4BEEF)});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule